// File: doc/BRIEF.md
# Receive byte ordering realigner

This block sits behind a receive byte deserializer. After reset the deserializer can start on either byte of a transmitted word, so one transmitted word may arrive split across two consecutive input words. The realigner restores the transmitted order. It watches the incoming words for a configured ordering pattern, which the transmitter always places in the low position of a word. When that pattern turns up in the high position, the block inserts PAD bytes into the stream so that the pattern, and all data after it, moves to the low position. No data byte is dropped.

The block has two word modes. In two-lane mode each word holds two bytes, and the unit of realignment is one byte. In four-lane mode each word holds four bytes, and the unit is a two-byte group. The byte width is a parameter (8 or 10). The mode, the pattern and the PAD value are captured while reset is held. Once ordering has happened, the shift is frozen until reset or a re-arm pulse.

Top module: `byte_order_realign`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid`, `ordered` and `out_data` are all zero.
- R2: `cfg_dbl`, `cfg_pattern` and `cfg_pad` are captured only while `rst` is high. Changing them after reset has no effect on the output.
- R3: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, no word is consumed, and any held byte is kept for the next valid word.
- R4: While searching, a word whose units do not match the pattern is forwarded unchanged one cycle later, and `ordered` stays low.
- R5: While searching, if the low unit equals the pattern, the word is forwarded unchanged. The block then locks with no shift, and `ordered` goes high together with that output word.
- R6: While searching, if only the high unit equals the pattern:
  - The output word is {PAD unit, low unit}.
  - From then on, each output word is {current low unit, previous high unit}.
  - `ordered` goes high with the next valid output, whose low unit is the pattern.
- R7: If both units equal the pattern, the low unit wins and no PAD is inserted.
- R8: Once locked, a pattern in either unit causes no new insertion, and `ordered` stays high until `rst` or `rearm`.
- R9: A high `rearm` clears the lock, the shift and `ordered` (low on the next cycle). A word accepted in that same cycle is forwarded unshifted. Searching resumes on the following word.
- R10: In two-lane mode (`cfg_dbl`=0):
  - The low byte is `in_data[BW-1:0]` and the high byte is `in_data[2*BW-1:BW]`.
  - Only `cfg_pattern[BW-1:0]` is compared.
  - `out_data[4*BW-1:2*BW]` is zero.
- R11: In four-lane mode (`cfg_dbl`=1):
  - The units are `in_data[2*BW-1:0]` (low) and `in_data[4*BW-1:2*BW]` (high).
  - The full `cfg_pattern` is compared.
  - The PAD unit is `cfg_pad` repeated twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| rearm | input | 1 | Drops the lock and restarts the pattern search |
| cfg_dbl | input | 1 | 0 = two-lane words, 1 = four-lane words |
| cfg_pattern | input | 2*BW | Ordering pattern (low byte only in two-lane mode) |
| cfg_pad | input | BW | PAD byte value |
| in_valid | input | 1 | Input word present |
| in_data | input | 4*BW | Deserialized input word |
| out_valid | output | 1 | Output word present |
| out_data | output | 4*BW | Realigned output word |
| ordered | output | 1 | High once the pattern sits in the low position of the output |

## Verification
The bench builds the block with the default byte width of 8. It exercises both word modes by changing `cfg_dbl` across resets. This covers:
- single-byte PAD insertion and two-byte group PAD insertion;
- the zeroed upper half in two-lane mode;
- a held byte carried across an idle cycle.

A 10-bit byte width is not built, so the handling of 10-bit codes relies only on the parameterized slicing.

// File: rtl/byte_order_realign.sv
module byte_order_realign #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rearm,
  input  logic            cfg_dbl,
  input  logic [2*BW-1:0] cfg_pattern,
  input  logic [BW-1:0]   cfg_pad,
  input  logic            in_valid,
  input  logic [4*BW-1:0] in_data,
  output logic            out_valid,
  output logic [4*BW-1:0] out_data,
  output logic            ordered
);
  localparam int H = 2 * BW;
  localparam int W = 4 * BW;

  logic          dbl_q;
  logic [H-1:0]  pat_q;
  logic [BW-1:0] pad_q;
  logic          locked, shift_q, pend;
  logic [H-1:0]  hold_q;

  always_ff @(posedge clk)
    if (rst) begin
      dbl_q <= cfg_dbl;
      pat_q <= cfg_pattern;
      pad_q <= cfg_pad;
    end

  logic [H-1:0] lo_u, hi_u, pat_u, pad_u, sel_hi, sel_lo;
  logic         searching, lo_hit, hi_hit, use_shift;
  logic [W-1:0] packed_w;

  assign lo_u  = dbl_q ? in_data[H-1:0] : {{BW{1'b0}}, in_data[BW-1:0]};
  assign hi_u  = dbl_q ? in_data[W-1:H] : {{BW{1'b0}}, in_data[H-1:BW]};
  assign pat_u = dbl_q ? pat_q : {{BW{1'b0}}, pat_q[BW-1:0]};
  assign pad_u = dbl_q ? {pad_q, pad_q} : {{BW{1'b0}}, pad_q};

  assign searching = !locked && !rearm;
  assign lo_hit    = searching && (lo_u == pat_u);
  assign hi_hit    = searching && !lo_hit && (hi_u == pat_u);
  assign use_shift = shift_q && !rearm;

  assign sel_hi = use_shift ? lo_u : (hi_hit ? pad_u : hi_u);
  assign sel_lo = use_shift ? hold_q : lo_u;
  assign packed_w = dbl_q ? {sel_hi, sel_lo}
                          : {{H{1'b0}}, sel_hi[BW-1:0], sel_lo[BW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      ordered   <= 1'b0;
      locked    <= 1'b0;
      shift_q   <= 1'b0;
      pend      <= 1'b0;
      hold_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (rearm) begin
        locked  <= 1'b0;
        shift_q <= 1'b0;
        pend    <= 1'b0;
        ordered <= 1'b0;
      end
      if (in_valid) begin
        out_data <= packed_w;
        hold_q   <= hi_u;
        if (lo_hit) begin
          locked  <= 1'b1;
          ordered <= 1'b1;
        end
        if (hi_hit) begin
          locked  <= 1'b1;
          shift_q <= 1'b1;
          pend    <= 1'b1;
        end
        if (pend && !rearm) begin
          ordered <= 1'b1;
          pend    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/byte_order_realign_chk.sv
module byte_order_realign_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            rearm,
  input logic            in_valid,
  input logic            out_valid,
  input logic            ordered,
  input logic            dbl,
  input logic [4*BW-1:0] out_data
);
  assert_valid_follow_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follow_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ordered && !rearm) |=> ordered);
  assert_rearm_clears_R9: assert property (@(posedge clk) disable iff (rst)
    rearm |=> !ordered);
  assert_rise_with_word_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ordered) |-> out_valid);
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !dbl |-> (out_data[4*BW-1:2*BW] == '0));
endmodule

bind byte_order_realign byte_order_realign_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .rearm(rearm), .in_valid(in_valid),
  .out_valid(out_valid), .ordered(ordered), .dbl(dbl_q), .out_data(out_data)
);

// File: tb/sim_byte_order_realign.sv
module sim_byte_order_realign;
  localparam int BW = 8;
  localparam int W  = 4 * BW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rearm = 1'b0;
  logic            cfg_dbl = 1'b0;
  logic [2*BW-1:0] cfg_pattern = '0;
  logic [BW-1:0]   cfg_pad = '0;
  logic            in_valid = 1'b0;
  logic [W-1:0]    in_data = '0;
  logic            out_valid;
  logic [W-1:0]    out_data;
  logic            ordered;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  byte_order_realign #(.BW(BW)) u0 (
    .clk(clk), .rst(rst), .rearm(rearm), .cfg_dbl(cfg_dbl),
    .cfg_pattern(cfg_pattern), .cfg_pad(cfg_pad), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .ordered(ordered)
  );

  // {input word, expected output word, expected ordered}, two-lane, pattern BC, pad 9C
  localparam logic [64:0] VEC [5] = '{
    {32'h0000_1122, 32'h0000_1122, 1'b0},
    {32'h0000_BC33, 32'h0000_9C33, 1'b0},
    {32'h0000_5544, 32'h0000_44BC, 1'b1},
    {32'h0000_77BC, 32'h0000_BC55, 1'b1},
    {32'h0000_BC66, 32'h0000_6677, 1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dbl, input logic [2*BW-1:0] pat, input logic [BW-1:0] pad);
    @(negedge clk);
    rst = 1'b1; rearm = 1'b0; in_valid = 1'b0;
    cfg_dbl = dbl; cfg_pattern = pat; cfg_pad = pad;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic v, input logic [W-1:0] d);
    in_valid = v; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [W-1:0] d, input logic ord);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, out_data, d);
    chk(req, {31'd0, ordered}, {31'd0, ord});
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state while held and just after release
    do_reset(1'b0, 16'h00BC, 8'h9C);
    chk("R1", {30'd0, out_valid, ordered}, 32'd0);
    chk("R1", out_data, 32'd0);
    @(negedge clk);
    chk("R1", {30'd0, out_valid, ordered}, 32'd0);

    // R4 R6 R8: vector table, two-lane shift case
    foreach (VEC[i]) begin
      step(1'b1, VEC[i][64:33]);
      expect_word("R6", VEC[i][32:1], VEC[i][0]);
    end

    // R9: rearm drops lock; word in same cycle unshifted; search resumes
    rearm = 1'b1;
    step(1'b1, 32'h0000_2211);
    rearm = 1'b0;
    expect_word("R9", 32'h0000_2211, 1'b0);
    step(1'b1, 32'h0000_BC77);
    expect_word("R9", 32'h0000_9C77, 1'b0);
    step(1'b1, 32'h0000_0099);
    expect_word("R9", 32'h0000_99BC, 1'b1);

    // R2 R5 R10: config change ignored, upper half zero, low-lane hit
    do_reset(1'b0, 16'h00BC, 8'h9C);
    cfg_pattern = 16'h00AA; cfg_pad = 8'h11; cfg_dbl = 1'b1;
    step(1'b1, 32'hDEAD_11BC);
    expect_word("R2", 32'h0000_11BC, 1'b1);
    // R8: locked, pattern in high byte inserts nothing
    step(1'b1, 32'h0000_BC34);
    expect_word("R8", 32'h0000_BC34, 1'b1);

    // R7: both bytes match, low wins
    do_reset(1'b0, 16'h00BC, 8'h9C);
    step(1'b1, 32'h0000_BCBC);
    expect_word("R7", 32'h0000_BCBC, 1'b1);

    // R11 R3: four-lane with idle gap
    do_reset(1'b1, 16'hF7BC, 8'h9C);
    step(1'b1, 32'hF7BC_1122);
    expect_word("R11", 32'h9C9C_1122, 1'b0);
    step(1'b0, 32'hFFFF_FFFF);
    chk("R3", {30'd0, out_valid, ordered}, 32'd0);
    step(1'b1, 32'h5566_4433);
    expect_word("R11", 32'h4433_F7BC, 1'b1);
    step(1'b1, 32'h9988_7766);
    expect_word("R11", 32'h7766_5566, 1'b1);

    // R4: four-lane no match passes unchanged
    do_reset(1'b1, 16'hF7BC, 8'h9C);
    step(1'b1, 32'h1234_5678);
    expect_word("R4", 32'h1234_5678, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule